// File: doc/BRIEF.md
# Tapped 64-Stage Serial Shift Register

This block is a static 64-stage serial shift register. It is split into four 16-stage segments, and the end of each segment is brought out as a tap. The last tap is the serial output of the whole chain. The register advances only on a rising clock edge on which the step handshake is valid. Between steps it holds its contents for as long as needed.

Write enable selects how the segments are fed:

- **Write enable low.** Each segment takes its input from the tail of the segment before it, so the register behaves as one continuous 64-bit chain.
- **Write enable high.** The heads of segments two, three and four take their bits from a three-bit tap-input bus. Segment one still takes the serial input. The four segments then fill in parallel, and a full 64-bit word loads in 16 steps.

Each tap has its own drive enable, so that a surrounding pad or bus stage can share one line for reading and writing. The drive enables are released while write enable is high.

The input stream uses a valid/ready handshake. `step_valid` marks a step, and `step_ready` is tied high: the register never applies back-pressure. A step is taken on every rising edge where `step_valid` is 1 and the synchronous clear is low. The tap outputs are plain levels with no handshake.

Top module: `tap_shift64`

## Requirements
- R1: A high `clr` on a rising edge sets all 64 stages to 0, whatever the other inputs. After that edge, all four bits of `tap_q` read 0.
- R2: `step_ready` is always 1. A step is never refused.
- R3: On an edge with `step_valid` low, the contents do not change, even if `ser_in`, `wr_en` or `tap_in` change.
- R4: With `wr_en` low, a step moves every bit one stage along the chain. A bit taken from `ser_in` shows on `tap_q[0]` after 16 steps, `tap_q[1]` after 32, `tap_q[2]` after 48 and `tap_q[3]` after 64.
- R5: With `wr_en` high, a step loads `tap_in[0]`, `tap_in[1]` and `tap_in[2]` into the first stages of segments two, three and four. Segment one loads `ser_in` on the same step.
- R6: Loading takes 16 steps with `wr_en` high. Then 64 steps with `wr_en` low present the loaded word on `tap_q[3]` in this order: the `tap_in[2]` stream, then the `tap_in[1]` stream, then the `tap_in[0]` stream, then the `ser_in` stream. Each stream comes out oldest bit first.
- R7: `tap_drv` is 4'b1111 when `out_en` is 1 and `wr_en` is 0. It is 4'b0000 otherwise. It follows those inputs combinationally.
- R8: `tap_q[k]` always shows the last stage of segment k+1, whatever the state of `tap_drv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of all stages |
| step_valid | input | 1 | Take one shift or load step on this edge |
| step_ready | output | 1 | Always 1; the register never stalls |
| ser_in | input | 1 | Serial data into stage 1 |
| wr_en | input | 1 | 1: segmented parallel load; 0: single chain |
| out_en | input | 1 | Enables the tap drivers when not writing |
| tap_in | input | 3 | Bits for the heads of segments 2, 3 and 4 |
| tap_q | output | 4 | Values after stages 16, 32, 48 and 64 |
| tap_drv | output | 4 | Per-tap drive enable |

## Verification
The hardest case to reach from the ports is showing that the segmented load and the continuous chain agree bit for bit across all three segment seams. Four distinct 16-bit streams are written in write mode. The bench then shifts plainly for 64 steps, while a scoreboard compares the last tap against the expected concatenation. Any misrouted seam or reversed segment therefore shows up as a wrong bit at a known step. The hold case is reached by freezing `step_valid` while the data and tap inputs toggle.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  parameter int unsigned SEG_LEN_DEF = 16;
  parameter int unsigned NUM_SEG_DEF = 4;
  localparam int unsigned TOTAL_DEF  = SEG_LEN_DEF * NUM_SEG_DEF;

  typedef enum logic {
    FEED_CHAIN = 1'b0,
    FEED_TAP   = 1'b1
  } feed_mode_e;
endpackage

// File: rtl/tapsr_segment.sv
module tapsr_segment #(
  parameter int unsigned LEN = 16
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           adv,
  input  logic           din,
  output logic [LEN-1:0] stages
);
  always_ff @(posedge clk) begin
    if (clr)      stages <= '0;
    else if (adv) stages <= {stages[LEN-2:0], din};
  end

  // R1: clear empties the segment on the next edge
  p_clear_r1: assert property (@(posedge clk) clr |=> (stages == '0));
  // R3: no step, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    !adv |=> $stable(stages));
  // R4: the tail leaving the segment was the stage before it one step ago
  p_tail_r4: assert property (@(posedge clk) disable iff (clr)
    adv |=> (stages[LEN-1] == $past(stages[LEN-2])));
endmodule

// File: rtl/tapsr_tap_drive.sv
module tapsr_tap_drive #(
  parameter int unsigned N = 4
) (
  input  logic         out_en,
  input  logic         wr_en,
  input  logic [N-1:0] tails,
  output logic [N-1:0] tap_q,
  output logic [N-1:0] tap_drv
);
  for (genvar k = 0; k < N; k++) begin : g_tap
    assign tap_q[k]   = tails[k];
    assign tap_drv[k] = out_en & ~wr_en;
  end

  always_comb begin
    // R7: drivers are released whenever the taps act as inputs
    p_release_r7: assert (!(wr_en && (tap_drv != '0)));
  end
endmodule

// File: rtl/tap_shift64.sv
module tap_shift64
  import tapsr_pkg::*;
#(
  parameter int unsigned SEG_LEN = SEG_LEN_DEF,
  parameter int unsigned NUM_SEG = NUM_SEG_DEF
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               step_valid,
  output logic               step_ready,
  input  logic               ser_in,
  input  logic               wr_en,
  input  logic               out_en,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_q,
  output logic [NUM_SEG-1:0] tap_drv
);
  localparam int unsigned TOTAL = SEG_LEN * NUM_SEG;

  feed_mode_e         mode;
  logic               adv;
  logic [NUM_SEG-1:0] heads_in;
  logic [NUM_SEG-1:0] tails;
  logic [SEG_LEN-1:0] seg_q [NUM_SEG];

  assign step_ready = 1'b1;
  assign adv        = step_valid & step_ready & ~clr;
  assign mode       = wr_en ? FEED_TAP : FEED_CHAIN;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_head
      assign heads_in[k] = ser_in;
    end else begin : g_seam
      assign heads_in[k] = (mode == FEED_TAP) ? tap_in[k-1] : tails[k-1];

      // R4: seams pass the previous tail in chain mode
      p_link_r4: assert property (@(posedge clk) disable iff (clr)
        (step_valid && !wr_en) |=> (seg_q[k][0] == $past(tails[k-1])));
      // R5: seams load the tap input in write mode
      p_load_r5: assert property (@(posedge clk) disable iff (clr)
        (step_valid && wr_en) |=> (seg_q[k][0] == $past(tap_in[k-1])));
    end

    tapsr_segment #(.LEN(SEG_LEN)) u_seg (
      .clk    (clk),
      .clr    (clr),
      .adv    (adv),
      .din    (heads_in[k]),
      .stages (seg_q[k])
    );
    assign tails[k] = seg_q[k][SEG_LEN-1];
  end

  tapsr_tap_drive #(.N(NUM_SEG)) u_drive (
    .out_en  (out_en),
    .wr_en   (wr_en),
    .tails   (tails),
    .tap_q   (tap_q),
    .tap_drv (tap_drv)
  );

  initial begin
    p_size_r4: assert (TOTAL == SEG_LEN * NUM_SEG && SEG_LEN > 1);
  end
endmodule

// File: tb/tap_shift64_bench.sv
module tap_shift64_bench;
  logic       clk = 1'b0;
  logic       clr, step_valid, ser_in, wr_en, out_en;
  logic [2:0] tap_in;
  logic       step_ready;
  logic [3:0] tap_q, tap_drv;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit exp_q[$];

  always #4 clk = ~clk;

  tap_shift64 u_tap_shift64 (
    .clk(clk), .clr(clr), .step_valid(step_valid), .step_ready(step_ready),
    .ser_in(ser_in), .wr_en(wr_en), .out_en(out_en), .tap_in(tap_in),
    .tap_q(tap_q), .tap_drv(tap_drv)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic [2:0] t);
    @(posedge clk); #1;
    step_valid = 1'b1; ser_in = s; wr_en = w; tap_in = t;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    step_valid = 1'b0;
  endtask

  // monitor: compares the last tap before every monitored step
  always @(negedge clk) begin
    if (mon_en && step_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: actual unexpected step expected empty queue");
      end else begin
        bit e;
        e = exp_q.pop_front();
        chk("R6", {3'b0, tap_q[3]}, {3'b0, e});
      end
    end
  end

  task automatic run_all();
    logic [15:0] a0, a1, a2, a3;
    logic [63:0] pat;
    logic [3:0]  snap;
    a0 = 16'hA5C3; a1 = 16'h3C96; a2 = 16'hF00D; a3 = 16'h1E2B;
    pat = 64'hDEAD_BEEF_0123_4567;

    // R1 clear from time zero
    clr = 1'b1; step_valid = 1'b0; ser_in = 1'b1; wr_en = 1'b0; out_en = 1'b1; tap_in = 3'b111;
    repeat (2) @(posedge clk);
    #1 clr = 1'b0;
    @(negedge clk);
    chk("R1 reset", tap_q, 4'b0000);
    chk("R2 ready", {3'b0, step_ready}, 4'b0001);

    // R7 drive enables
    out_en = 1'b1; wr_en = 1'b0; #1 chk("R7 oe=1 we=0", tap_drv, 4'b1111);
    out_en = 1'b1; wr_en = 1'b1; #1 chk("R7 oe=1 we=1", tap_drv, 4'b0000);
    out_en = 1'b0; wr_en = 1'b0; #1 chk("R7 oe=0 we=0", tap_drv, 4'b0000);
    out_en = 1'b0; wr_en = 1'b1; #1 chk("R7 oe=0 we=1", tap_drv, 4'b0000);
    out_en = 1'b1; wr_en = 1'b0;

    // R5 segmented load: 16 steps, four streams
    for (int i = 0; i < 16; i++) step(a0[i], 1'b1, {a3[i], a2[i], a1[i]});
    idle();
    @(negedge clk);
    // R5/R8: each tail holds the oldest bit written to its segment
    chk("R5 tails after load", tap_q, {a3[0], a2[0], a1[0], a0[0]});
    chk("R8 tap visible while released", {3'b0, tap_drv[0]}, 4'b0000);

    // R3 hold: inputs churn with no step
    snap = tap_q;
    wr_en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1 ser_in = ~ser_in; tap_in = ~tap_in; wr_en = ~wr_en;
    end
    wr_en = 1'b0;
    @(negedge clk);
    chk("R3 hold", tap_q, snap);
    chk("R8 tap driven", tap_drv, 4'b1111);

    // R6 scoreboard: expected order on the last tap
    for (int i = 0; i < 16; i++) exp_q.push_back(a3[i]);
    for (int i = 0; i < 16; i++) exp_q.push_back(a2[i]);
    for (int i = 0; i < 16; i++) exp_q.push_back(a1[i]);
    for (int i = 0; i < 16; i++) exp_q.push_back(a0[i]);
    mon_en = 1'b1;
    for (int i = 0; i < 64; i++) step(pat[i], 1'b0, 3'b101);
    idle();
    @(negedge clk);
    mon_en = 1'b0;
    chk("R6 queue drained", {3'b0, exp_q.size() == 0}, 4'b0001);

    // R4 chain: the pattern fed serially lands at 16/32/48/64 step delays
    chk("R4 chain taps", tap_q, {pat[0], pat[16], pat[32], pat[48]});

    // R1 clear wins over a valid step
    @(posedge clk); #1 step_valid = 1'b1; ser_in = 1'b1; clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0; step_valid = 1'b0;
    @(negedge clk);
    chk("R1 clear over step", tap_q, 4'b0000);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule